// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the array address for each beat of a four-beat burst. When a burst-start strobe is accepted, it captures an external word address. It then produces the next addresses itself by stepping only the two least significant bits. The upper bits stay at the value captured on load. The low bits follow one of two orders, and a static select input chooses between them. Linear order counts upward modulo four from the loaded start. Interleaved order is the start value XOR a beat count that runs 0, 1, 2, 3.

There are two active-low start strobes. The controller-side strobe always loads. The processor-side strobe loads only while the primary chip-select (active low) is asserted. While both strobes are idle, an active-low advance input either moves the burst forward by one beat or holds the current address. The output address comes straight from the captured base and beat count, so it changes on the clock edge that follows a load or an advance.

Top module: `burst_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the base and the beat count clear, so `cur_addr` reads all zeros from the next edge onward.
- R2: `start_ctrl_n` low at an edge loads `ext_addr`, whatever the level of `cs_n`. `cur_addr` equals that address after the edge, because the beat count restarts at 0.
- R3: `start_proc_n` low with `cs_n` low loads `ext_addr`. `start_proc_n` low with `cs_n` high and `start_ctrl_n` high is ignored: `cur_addr` keeps its value and does not advance, even with `adv_n` low.
- R4: With `order_il` = 0 (linear), beat k of a burst has low two bits equal to (start + k) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R5: With `order_il` = 1 (interleaved), beat k has low two bits equal to start XOR k. For example, start 01 gives 01, 00, 11, 10.
- R6: `order_il` is not registered. A change on it reaches `cur_addr` without a clock edge.
- R7: With both start strobes high, `adv_n` low at an edge steps one beat and `adv_n` high holds `cur_addr`.
- R8: Bits above bit 1 of `cur_addr` keep the value captured on load while the burst steps or holds.
- R9: An advance after the fourth beat wraps back to the first address of the sequence.
- R10: A load aborts any burst in progress and restarts the beat count at 0. A load takes priority over `adv_n`, including when both strobes are low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_proc_n | input | 1 | Processor-side burst start, active low, gated by `cs_n` |
| start_ctrl_n | input | 1 | Controller-side burst start, active low, always loads |
| cs_n | input | 1 | Primary chip-select, active low |
| adv_n | input | 1 | Advance, active low; high holds |
| order_il | input | 1 | Order select, static: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | External word address |
| cur_addr | output | ADDR_W | Current array address |

## Verification
The hardest case to reach from the ports is a new load arriving in the middle of a burst while `adv_n` is also asserted. The bench steps a burst partway, then pulls one or both strobes low with `adv_n` held low. It checks that the new start comes out unchanged and that the following beats count from it. A second awkward case is the combinational path from `order_il`. The bench flips the select between clock edges in the middle of a burst and samples `cur_addr` before the next edge.

// File: rtl/bseq_pkg.sv
// Shared types for the burst address sequencer.
package bseq_pkg;
    // Order of the low address bits across a burst.
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    // Action taken at the next clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } act_e;
endpackage

// File: rtl/bseq_start_ctl.sv
// Decides the action for the next edge from the start strobes,
// chip-select and advance input.
// Assumes all inputs are synchronous to the consuming clock.
module bseq_start_ctl
    import bseq_pkg::*;
(
    input  logic start_proc_n,
    input  logic start_ctrl_n,
    input  logic cs_n,
    input  logic adv_n,
    output act_e act
);
    logic proc_ok;
    logic any_strobe;

    // The processor-side strobe counts only while chip-select is asserted.
    assign proc_ok    = !start_proc_n && !cs_n;
    assign any_strobe = !start_proc_n || !start_ctrl_n;

    // Priority: load, then step (only with both strobes idle), then hold.
    always_comb begin
        if (!start_ctrl_n || proc_ok)
            act = ACT_LOAD;
        else if (!any_strobe && !adv_n)
            act = ACT_STEP;
        else
            act = ACT_HOLD;
    end
endmodule

// File: rtl/bseq_beat_ctr.sv
// Holds the captured base address and the beat count of the burst.
// Assumes the action is settled before each rising edge.
module bseq_beat_ctr
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int SEQ_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              act,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base,
    output logic [SEQ_W-1:0]  beat
);
    localparam logic [SEQ_W-1:0] BEAT_ONE = 1;

    // Capture on load, count on step, keep on hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            beat <= '0;
        end else begin
            case (act)
                ACT_LOAD: begin
                    base <= ext_addr;
                    beat <= '0;
                end
                ACT_STEP: beat <= beat + BEAT_ONE;
                default:  ;
            endcase
        end
    end

    // R10: a load restarts the beat count.
    a_r10_load_clears_beat: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_LOAD |=> beat == '0);

    // R9: a step moves exactly one beat, wrapping past the last.
    a_r9_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_STEP |=> beat == $past(beat) + BEAT_ONE);
endmodule

// File: rtl/bseq_order_map.sv
// Maps start bits and beat count to the low address bits in linear
// or XOR-interleaved order. Purely combinational.
module bseq_order_map
    import bseq_pkg::*;
#(
    parameter int SEQ_W = 2
) (
    input  logic [SEQ_W-1:0] start_lo,
    input  logic [SEQ_W-1:0] beat,
    input  order_e           order,
    output logic [SEQ_W-1:0] addr_lo
);
    logic [SEQ_W-1:0] lin_lo;
    logic [SEQ_W-1:0] xor_lo;

    // Linear order: modulo add of the beat count.
    assign lin_lo = start_lo + beat;

    // Interleaved order: bitwise XOR, one bit per generated slice.
    for (genvar i = 0; i < SEQ_W; i++) begin : g_xor
        assign xor_lo[i] = start_lo[i] ^ beat[i];
    end

    // Select the order chosen by the static input.
    assign addr_lo = (order == ORD_XOR) ? xor_lo : lin_lo;
endmodule

// File: rtl/burst_seq.sv
// Top of the burst address sequencer: start decode, base/beat
// registers and order mapping. order_il is used unregistered and
// is expected to be static during a burst.
module burst_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int SEQ_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_proc_n,
    input  logic              start_ctrl_n,
    input  logic              cs_n,
    input  logic              adv_n,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    act_e             act;
    logic [ADDR_W-1:0] base;
    logic [SEQ_W-1:0]  beat;
    logic [SEQ_W-1:0]  addr_lo;

    bseq_start_ctl u_ctl (
        .start_proc_n (start_proc_n),
        .start_ctrl_n (start_ctrl_n),
        .cs_n         (cs_n),
        .adv_n        (adv_n),
        .act          (act)
    );

    bseq_beat_ctr #(.ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .ext_addr (ext_addr),
        .base     (base),
        .beat     (beat)
    );

    bseq_order_map #(.SEQ_W(SEQ_W)) u_map (
        .start_lo (base[SEQ_W-1:0]),
        .beat     (beat),
        .order    (order_e'(order_il)),
        .addr_lo  (addr_lo)
    );

    // Join the frozen upper bits with the sequenced low bits.
    assign cur_addr = {base[ADDR_W-1:SEQ_W], addr_lo};

    // R1: reset yields an all-zero address.
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> cur_addr == '0);

    // R2: the controller strobe always loads the external address.
    a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        !start_ctrl_n |=> cur_addr == $past(ext_addr));

    // R3: a processor strobe blocked by chip-select changes nothing.
    a_r3_proc_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ctrl_n && !start_proc_n && cs_n)
        |=> ($stable(cur_addr) || !$stable(order_il)));

    // R7: idle strobes with advance high hold the address.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ctrl_n && start_proc_n && adv_n)
        |=> ($stable(cur_addr) || !$stable(order_il)));

    // R8: without a load the upper bits never move.
    a_r8_upper_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ctrl_n && (start_proc_n || cs_n))
        |=> $stable(cur_addr[ADDR_W-1:SEQ_W]));
endmodule

// File: tb/burst_seq_test.sv
// Directed bench for burst_seq: one task per scenario.
module burst_seq_test;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_proc_n = 1'b1;
    logic          start_ctrl_n = 1'b1;
    logic          cs_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_il = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] cur_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    burst_seq #(.ADDR_W(AW), .SEQ_W(2)) uut (
        .clk (clk), .rst_n (rst_n), .start_proc_n (start_proc_n),
        .start_ctrl_n (start_ctrl_n), .cs_n (cs_n), .adv_n (adv_n),
        .order_il (order_il), .ext_addr (ext_addr), .cur_addr (cur_addr)
    );

    always #10 clk = ~clk;

    // Wait for the edge, then move clear of it before sampling.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        start_proc_n = 1'b1; start_ctrl_n = 1'b1; cs_n = 1'b1; adv_n = 1'b1;
    endtask

    function automatic logic [AW-1:0] expect_beat(input logic [AW-1:0] a,
                                                  input int k, input bit il);
        logic [1:0] s;
        logic [1:0] kk;
        s = a[1:0];
        kk = 2'(k);
        return {a[AW-1:2], il ? (s ^ kk) : 2'(s + kk)};
    endfunction

    task automatic ctrl_load(input logic [AW-1:0] a);
        idle(); start_ctrl_n = 1'b0; ext_addr = a;
        tick();
        idle();
    endtask

    task automatic t_reset();
        idle();
        rst_n = 1'b0;
        tick(); tick();
        check("R1 reset", cur_addr, '0);
        rst_n = 1'b1;
        tick();
        check("R1 after release", cur_addr, '0);
    endtask

    // R4/R5/R8/R9: full burst plus wrap for each start in one order.
    task automatic t_burst(input bit il);
        order_il = il;
        for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] a;
            a = {16'h9C3A + 16'(s), 2'(s)};
            ctrl_load(a);
            check("R2 load", cur_addr, a);
            for (int k = 1; k <= 4; k++) begin
                adv_n = 1'b0;
                tick();
                check(il ? "R5 interleaved" : "R4 linear", cur_addr,
                      expect_beat(a, k % 4, il));
            end
            check("R9 wrap", cur_addr, a);
            check("R8 upper", {cur_addr[AW-1:2], 2'b00}, {a[AW-1:2], 2'b00});
            idle();
        end
    endtask

    task automatic t_hold();
        logic [AW-1:0] a;
        a = 18'h2_1235;
        order_il = 1'b0;
        ctrl_load(a);
        adv_n = 1'b0; tick(); idle();
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R7 hold", cur_addr, expect_beat(a, 1, 1'b0));
        end
        adv_n = 1'b0; tick(); idle();
        check("R7 resume", cur_addr, expect_beat(a, 2, 1'b0));
    endtask

    task automatic t_proc();
        logic [AW-1:0] a;
        logic [AW-1:0] b;
        a = 18'h0_4446;
        b = 18'h3_0F01;
        order_il = 1'b0;
        ctrl_load(a);
        start_proc_n = 1'b0; cs_n = 1'b1; adv_n = 1'b0; ext_addr = b;
        tick();
        check("R3 proc blocked", cur_addr, a);
        tick();
        check("R3 proc blocked no step", cur_addr, a);
        cs_n = 1'b0; adv_n = 1'b1;
        tick(); idle();
        check("R3 proc load", cur_addr, b);
        cs_n = 1'b1; start_ctrl_n = 1'b0; ext_addr = a;
        tick(); idle();
        check("R2 ctrl ignores cs", cur_addr, a);
    endtask

    task automatic t_abort();
        logic [AW-1:0] a;
        logic [AW-1:0] b;
        logic [AW-1:0] c;
        a = 18'h1_5552;
        b = 18'h2_AAA9;
        c = 18'h0_7777;
        order_il = 1'b1;
        ctrl_load(a);
        adv_n = 1'b0; tick(); tick();
        check("R5 mid burst", cur_addr, expect_beat(a, 2, 1'b1));
        start_ctrl_n = 1'b0; ext_addr = b;
        tick();
        check("R10 abort load", cur_addr, b);
        start_ctrl_n = 1'b1;
        tick();
        check("R10 restart beat", cur_addr, expect_beat(b, 1, 1'b1));
        start_ctrl_n = 1'b0; start_proc_n = 1'b0; cs_n = 1'b0; ext_addr = c;
        tick(); idle();
        check("R10 both strobes", cur_addr, c);
    endtask

    task automatic t_order();
        logic [AW-1:0] a;
        a = 18'h3_2101;
        order_il = 1'b0;
        ctrl_load(a);
        adv_n = 1'b0; tick(); idle();
        check("R4 before flip", cur_addr, expect_beat(a, 1, 1'b0));
        #3 order_il = 1'b1;
        #1 check("R6 order comb", cur_addr, expect_beat(a, 1, 1'b1));
        #1 order_il = 1'b0;
        #1 check("R6 order back", cur_addr, expect_beat(a, 1, 1'b0));
    endtask

    task automatic t_reset_mid();
        ctrl_load(18'h3_FFFF);
        adv_n = 1'b0; tick(); idle();
        rst_n = 1'b0; tick();
        check("R1 reset mid burst", cur_addr, '0);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_burst(1'b0);
        t_burst(1'b1);
        t_hold();
        t_proc();
        t_abort();
        t_order();
        t_reset_mid();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule